// File: doc/BRIEF.md
# Doppler-Tuned Decimating Complex Sample Recorder

This block turns a stream of real, signed intermediate-frequency samples into complex baseband words for a processor to read through a DMA channel. Each accepted input sample is multiplied by a local carrier taken from a numerically controlled oscillator. The oscillator's step is the sum of a nominal IF control word and a signed Doppler offset, and both come from software. The I and Q products are summed over blocks of 32 samples, scaled, saturated to 16 bits and packed into one 32-bit word. The word is then offered on a valid/ready stream.

Software sets a word count and pulses `start`. The capture begins with a fresh phase and a fresh block. The value of a free-running time counter is kept from the first input sample the capture accepts, so software can tie the data to absolute time. A sticky flag reports that a word was lost because the stream was stalled. A second flag reports that the final word of the capture has been handed over.

Top module: `iqrec_capture`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `busy`, `done` and `overflow` are 0 and `capture_ts` is 0.
- R2: The carrier phase is a 32-bit accumulator that is cleared when a capture starts. An accepted sample x uses k = phase[31:29] and then adds the current step to the phase. The product for I is x*C[k] and for Q is x*C[(k+6) mod 8], with C = {127, 90, 0, -90, -127, -90, 0, 90} for k = 0..7.
- R3: Every 32 accepted samples yield exactly one word. Each lane is the sum of its 32 products, shifted right arithmetically by 4, and saturated to the signed 16-bit range [-32768, 32767].
- R4: The word has Q in bits [15:0] and I in bits [31:16]. It is presented with `out_valid` high from the cycle after the clock edge that takes the 32nd sample.
- R5: The phase step is if_fcw + doppler_fcw, read when a capture starts and again on the edge that takes each 32nd sample. That edge still advances the phase with the old step, so a Doppler change never alters a block already in progress.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: If a new word is complete while an earlier word is still pending and `out_ready` is low, the new word is dropped, is not counted, and `overflow` is set until the next start.
- R8: `capture_ts` takes the value of `time_now` on the first edge of a capture that takes a sample, and holds it until the next capture.
- R9: A start latches `word_count` (at least 1). `busy` falls when the word_count-th word is loaded. `done` rises on the cycle after that word is accepted, and `done` is cleared by the next start.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: `in_valid` while `busy` is low produces no word and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a capture |
| word_count | input | 16 | Number of words to record, latched at start |
| if_fcw | input | 32 | Nominal IF phase step |
| doppler_fcw | input | 32 | Signed Doppler phase-step offset |
| time_now | input | 48 | Free-running time counter |
| in_valid | input | 1 | Input sample present |
| in_sample | input | 12 | Signed real input sample |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Packed word available |
| out_data | output | 32 | Q in [15:0], I in [31:16] |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Final word of the capture has been accepted |
| overflow | output | 1 | Sticky: a word was dropped |
| capture_ts | output | 48 | Time of the first captured sample |

## Verification
Each result has a fixed latency. A packed word appears one cycle after the edge that takes its 32nd sample. `capture_ts` and `overflow` change on the edge of the causing sample, and `done` follows the accepting handshake by one cycle. The bench applies stimulus just after a falling edge and advances a cycle-exact reference of the requirements in step with the rising edge. It compares every output at the next falling edge, so each expected value is checked in the same cycle in which it becomes due. Directed checks also test full-scale saturation, the timestamp value, and the total number of accepted words.

// File: rtl/iqrec_pkg.sv
// Shared constants and the carrier lookup for the sample recorder.
// Assumes an 8-entry carrier table indexed by the top three phase bits.
package iqrec_pkg;
    localparam int CAR_W   = 8;
    localparam int LUT_IW  = 3;
    localparam int SIN_OFS = 6;   // sin(k*45deg) = cos((k-2)*45deg)

    // Cosine of k*45 degrees, scaled to 127.
    function automatic logic signed [CAR_W-1:0] cos_lut(input logic [LUT_IW-1:0] k);
        case (k)
            3'd0:    return 8'sd127;
            3'd1:    return 8'sd90;
            3'd2:    return 8'sd0;
            3'd3:    return -8'sd90;
            3'd4:    return -8'sd127;
            3'd5:    return -8'sd90;
            3'd6:    return 8'sd0;
            default: return 8'sd90;
        endcase
    endfunction
endpackage

// File: rtl/iqrec_nco.sv
// Carrier phase generator. Holds a phase accumulator and the active step.
// The step is reloaded from if_fcw + doppler_fcw only at capture start and
// on the last sample of a block, so a block never mixes two frequencies.
module iqrec_nco
    import iqrec_pkg::*;
#(
    parameter int PH_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              take,
    input  logic              blk_last,
    input  logic [PH_W-1:0]   if_fcw,
    input  logic [PH_W-1:0]   doppler_fcw,
    output logic [LUT_IW-1:0] lut_idx
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] fcw_act;

    // Phase advances by the active step on every taken sample.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (take)    phase_q <= phase_q + fcw_act;
    end

    // Step reload at capture start and at block boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fcw_act <= '0;
        else if (restart)               fcw_act <= if_fcw + doppler_fcw;
        else if (take && blk_last)      fcw_act <= if_fcw + doppler_fcw;
    end

    assign lut_idx = phase_q[PH_W-1 -: LUT_IW];

    // R5: step never changes inside a block.
    p_fcw_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(take && blk_last)) |=> $stable(fcw_act));
endmodule

// File: rtl/iqrec_mixdec.sv
// Carrier wipe-off and integrate-and-dump decimator, one generated lane
// each for I and Q. Assumes DEC is a power of two. The dump result is
// combinational on the last sample of a block; accumulators clear there.
module iqrec_mixdec
    import iqrec_pkg::*;
#(
    parameter int SAMP_W    = 12,
    parameter int DEC       = 32,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      take,
    input  logic signed [SAMP_W-1:0]  sample,
    input  logic [LUT_IW-1:0]         lut_idx,
    output logic                      blk_last,
    output logic                      dump_valid,
    output logic [2*OUT_W-1:0]        dump_word
);
    localparam int DEC_W  = $clog2(DEC);
    localparam int PROD_W = SAMP_W + CAR_W;
    localparam int ACC_W  = PROD_W + DEC_W;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2**(OUT_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(2**(OUT_W-1));

    logic [DEC_W-1:0]        idx_q;
    logic signed [CAR_W-1:0] coef   [2];
    logic [OUT_W-1:0]        lane_o [2];

    assign coef[0]  = cos_lut(lut_idx);
    assign coef[1]  = cos_lut(lut_idx + LUT_IW'(SIN_OFS));
    assign blk_last = (idx_q == DEC_W'(DEC - 1));

    // Sample position inside the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (restart) idx_q <= '0;
        else if (take)    idx_q <= blk_last ? '0 : idx_q + 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic signed [PROD_W-1:0] prod;
        logic signed [ACC_W-1:0]  acc_q;
        logic signed [ACC_W-1:0]  sum;
        logic signed [ACC_W-1:0]  scaled;

        assign prod   = sample * coef[g];
        assign sum    = acc_q + {{DEC_W{prod[PROD_W-1]}}, prod};
        assign scaled = sum >>> OUT_SHIFT;
        assign lane_o[g] = (scaled > SAT_HI) ? SAT_HI[OUT_W-1:0] :
                           (scaled < SAT_LO) ? SAT_LO[OUT_W-1:0] :
                           scaled[OUT_W-1:0];

        // Integrate, dumping to zero on the last sample of a block.
        always_ff @(posedge clk) begin
            if (!rst_n)       acc_q <= '0;
            else if (restart) acc_q <= '0;
            else if (take)    acc_q <= blk_last ? '0 : sum;
        end
    end

    assign dump_valid = take && blk_last;
    assign dump_word  = {lane_o[0], lane_o[1]};   // I high, Q low
endmodule

// File: rtl/iqrec_ctrl.sv
// Capture control and output stage: start handling, word counting,
// timestamp latch, single-entry output register with drop-on-stall.
// Assumes word_count >= 1 at start.
module iqrec_ctrl #(
    parameter int CNT_W  = 16,
    parameter int TS_W   = 48,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [TS_W-1:0]   time_now,
    input  logic              in_valid,
    input  logic              dump_valid,
    input  logic [WORD_W-1:0] dump_word,
    input  logic              out_ready,
    output logic              restart,
    output logic              take,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              busy,
    output logic              done,
    output logic              overflow,
    output logic [TS_W-1:0]   capture_ts
);
    logic [CNT_W-1:0] wc_q;
    logic [CNT_W-1:0] made_q;
    logic             last_pend;
    logic             ts_taken;
    logic             accept, stall, load, drop, last_word;

    assign restart   = start && !busy;
    assign take      = in_valid && busy;
    assign accept    = out_valid && out_ready;
    assign stall     = out_valid && !out_ready;
    assign load      = dump_valid && !stall;
    assign drop      = dump_valid && stall;
    assign last_word = ((made_q + 1'b1) == wc_q);

    // Word count latch and loaded-word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc_q   <= '0;
            made_q <= '0;
        end else if (restart) begin
            wc_q   <= word_count;
            made_q <= '0;
        end else if (load) begin
            made_q <= made_q + 1'b1;
        end
    end

    // Capture-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 busy <= 1'b0;
        else if (restart)           busy <= 1'b1;
        else if (load && last_word) busy <= 1'b0;
    end

    // Output register: load a new word, or empty on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= dump_word;
        end else if (accept) begin
            out_valid <= 1'b0;
        end
    end

    // Marks that the pending word is the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_pend <= 1'b0;
        else if (restart) last_pend <= 1'b0;
        else if (load)    last_pend <= last_word;
        else if (accept)  last_pend <= 1'b0;
    end

    // Completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                   done <= 1'b0;
        else if (restart)             done <= 1'b0;
        else if (accept && last_pend) done <= 1'b1;
    end

    // Sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       overflow <= 1'b0;
        else if (restart) overflow <= 1'b0;
        else if (drop)    overflow <= 1'b1;
    end

    // Timestamp of the first taken sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_taken   <= 1'b0;
            capture_ts <= '0;
        end else if (restart) begin
            ts_taken   <= 1'b0;
        end else if (take && !ts_taken) begin
            ts_taken   <= 1'b1;
            capture_ts <= time_now;
        end
    end

    // R6: a stalled word is held unchanged.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7: overflow only rises from a stalled output.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(out_valid && !out_ready));
    // R8: timestamp held once taken.
    p_ts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_taken && !start) |=> $stable(capture_ts));
    // R9: done only follows a handshake.
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));
    // R10: start while busy does not clear done or overflow.
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && overflow) |=> overflow);
endmodule

// File: rtl/iqrec_capture.sv
// Top of the Doppler-tuned decimating complex sample recorder.
// Connects the carrier generator, the mixer/decimator and the capture
// control. Assumes a power-of-two decimation factor of 32 by default.
module iqrec_capture #(
    parameter int SAMP_W    = 12,
    parameter int PH_W      = 32,
    parameter int DEC       = 32,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 4,
    parameter int CNT_W     = 16,
    parameter int TS_W      = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         word_count,
    input  logic [PH_W-1:0]          if_fcw,
    input  logic [PH_W-1:0]          doppler_fcw,
    input  logic [TS_W-1:0]          time_now,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_sample,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [2*OUT_W-1:0]       out_data,
    output logic                     busy,
    output logic                     done,
    output logic                     overflow,
    output logic [TS_W-1:0]          capture_ts
);
    import iqrec_pkg::*;
    localparam int WORD_W = 2 * OUT_W;

    logic              restart, take, blk_last, dump_valid;
    logic [LUT_IW-1:0] lut_idx;
    logic [WORD_W-1:0] dump_word;

    iqrec_nco #(.PH_W(PH_W)) i_nco (
        .clk(clk), .rst_n(rst_n), .restart(restart), .take(take),
        .blk_last(blk_last), .if_fcw(if_fcw), .doppler_fcw(doppler_fcw),
        .lut_idx(lut_idx)
    );

    iqrec_mixdec #(.SAMP_W(SAMP_W), .DEC(DEC), .OUT_W(OUT_W),
                   .OUT_SHIFT(OUT_SHIFT)) i_mixdec (
        .clk(clk), .rst_n(rst_n), .restart(restart), .take(take),
        .sample(in_sample), .lut_idx(lut_idx), .blk_last(blk_last),
        .dump_valid(dump_valid), .dump_word(dump_word)
    );

    iqrec_ctrl #(.CNT_W(CNT_W), .TS_W(TS_W), .WORD_W(WORD_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
        .time_now(time_now), .in_valid(in_valid), .dump_valid(dump_valid),
        .dump_word(dump_word), .out_ready(out_ready), .restart(restart),
        .take(take), .out_valid(out_valid), .out_data(out_data),
        .busy(busy), .done(done), .overflow(overflow),
        .capture_ts(capture_ts)
    );
endmodule

// File: tb/test_iqrec_capture.sv
// Self-checking bench: random and directed stimulus against a cycle-exact
// reference built from the requirements.
module test_iqrec_capture;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [15:0]        word_count = 16'd1;
    logic [31:0]        if_fcw = '0;
    logic [31:0]        doppler_fcw = '0;
    logic [47:0]        time_now = '0;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_sample = '0;
    logic               out_ready = 1'b0;
    logic               out_valid, busy, done, overflow;
    logic [31:0]        out_data;
    logic [47:0]        capture_ts;

    int checks = 0;
    int errors = 0;

    // reference state
    bit          m_busy, m_ov, m_ovf, m_done, m_lastp, m_tst;
    logic [31:0] m_phase, m_fcw, m_data;
    logic [47:0] m_ts;
    longint      m_ai, m_aq;
    int          m_idx, m_prod, m_wc;
    int          acc_cnt;
    logic [31:0] last_acc;
    logic [47:0] first_t;

    always #4 clk = ~clk;   // 125 MHz

    iqrec_capture i_iqrec_capture (
        .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
        .if_fcw(if_fcw), .doppler_fcw(doppler_fcw), .time_now(time_now),
        .in_valid(in_valid), .in_sample(in_sample), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .busy(busy),
        .done(done), .overflow(overflow), .capture_ts(capture_ts)
    );

    function automatic int ccos(int k);
        case (k & 7)
            0: return 127;  1: return 90;   2: return 0;  3: return -90;
            4: return -127; 5: return -90;  6: return 0;  default: return 90;
        endcase
    endfunction

    function automatic logic [15:0] bsat(longint v);
        longint s = v >>> 4;
        if (s > 32767)  return 16'h7fff;
        if (s < -32768) return 16'h8000;
        return s[15:0];
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare();
        chk(out_valid == m_ov, "R4 out_valid", out_valid, m_ov);
        if (m_ov) chk(out_data == m_data, "R3 out_data", out_data, m_data);
        chk(busy == m_busy, "R11 busy", busy, m_busy);
        chk(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
        chk(done == m_done, "R9 done", done, m_done);
        chk(capture_ts == m_ts, "R8 capture_ts", capture_ts, m_ts);
    endtask

    task automatic model_reset();
        m_busy = 0; m_ov = 0; m_ovf = 0; m_done = 0; m_lastp = 0; m_tst = 0;
        m_phase = 0; m_fcw = 0; m_data = 0; m_ts = 0;
        m_ai = 0; m_aq = 0; m_idx = 0; m_prod = 0; m_wc = 0;
    endtask

    // Advance the reference by one rising edge with the given inputs.
    task automatic model_step(bit st, bit iv, int x, bit rdy);
        bit restart = st && !m_busy;
        bit take    = iv && m_busy;
        bit accept  = m_ov && rdy;
        bit ld = 0;
        bit old_lastp = m_lastp;
        logic [31:0] w = '0;
        if (restart) begin
            m_busy = 1; m_phase = 0; m_idx = 0; m_ai = 0; m_aq = 0;
            m_fcw = if_fcw + doppler_fcw; m_tst = 0; m_ovf = 0;
            m_prod = 0; m_wc = int'(word_count);
        end
        if (take) begin
            int k = int'(m_phase[31:29]);
            longint si = m_ai + longint'(x * ccos(k));
            longint sq = m_aq + longint'(x * ccos(k + 6));
            if (!m_tst) begin m_ts = time_now; m_tst = 1; end
            m_phase = m_phase + m_fcw;
            if (m_idx == 31) begin
                w = {bsat(si), bsat(sq)};
                m_ai = 0; m_aq = 0;
                m_fcw = if_fcw + doppler_fcw;
                if (m_ov && !rdy) m_ovf = 1;
                else ld = 1;
                m_idx = 0;
            end else begin
                m_ai = si; m_aq = sq; m_idx++;
            end
        end
        if (restart) m_done = 0;
        else if (accept && old_lastp) m_done = 1;
        if (restart) m_lastp = 0;
        else if (ld) m_lastp = (m_prod + 1 == m_wc);
        else if (accept) m_lastp = 0;
        if (ld) begin
            if (m_prod + 1 == m_wc) m_busy = 0;
            m_prod++;
            m_ov = 1; m_data = w;
        end else if (accept) m_ov = 0;
    endtask

    task automatic tick(bit st, bit iv, int x, bit rdy);
        if (out_valid && rdy) begin acc_cnt++; last_acc = out_data; end
        start = st; in_valid = iv; in_sample = x[11:0]; out_ready = rdy;
        if (iv && m_busy && !m_tst) first_t = time_now;
        model_step(st, iv, x, rdy);
        @(posedge clk);
        @(negedge clk);
        time_now = time_now + 1;
        compare();
    endtask

    task automatic run_random(int iv_pct, int rdy_pct, int dop_pct);
        for (int c = 0; c < 6000 && (m_busy || m_ov); c++) begin
            if (($urandom % 100) < dop_pct) doppler_fcw = $urandom;
            tick(0, ($urandom % 100) < iv_pct, int'($urandom % 4096) - 2048,
                 ($urandom % 100) < rdy_pct);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && !busy && !done && !overflow, "R1 flags", {out_valid, busy, done, overflow}, 0);
        chk(capture_ts == 0, "R1 capture_ts", capture_ts, 0);
        rst_n = 1'b1;

        // R11: samples while idle are ignored
        for (int i = 0; i < 40; i++) tick(0, 1, 2000, 0);
        chk(out_valid == 0, "R11 idle no word", out_valid, 0);

        // R2 R3 R4: continuous capture with a fixed Doppler
        if_fcw = 32'h1234_5678; doppler_fcw = 32'h0001_0000; word_count = 16'd4;
        acc_cnt = 0;
        tick(1, 0, 0, 1);
        run_random(100, 100, 0);
        chk(acc_cnt == 4, "R9 word count", acc_cnt, 4);
        chk(done == 1, "R9 done set", done, 1);

        // R5 R6 R10: random gaps, stalls, mid-block Doppler changes, restart attempts
        word_count = 16'd6; acc_cnt = 0;
        tick(1, 0, 0, 1);
        for (int i = 0; i < 20; i++) begin
            word_count = 16'd1;
            tick(1, 1, int'($urandom % 4096) - 2048, 1);   // R10 ignored start
        end
        run_random(70, 85, 5);
        chk(acc_cnt == 6, "R10 start while busy ignored", acc_cnt, 6);

        // R8: timestamp of first taken sample after idle cycles
        word_count = 16'd2; acc_cnt = 0;
        tick(1, 0, 0, 1);
        for (int i = 0; i < 5; i++) tick(0, 0, 0, 1);
        tick(0, 1, 77, 1);
        chk(capture_ts == first_t, "R8 timestamp value", capture_ts, first_t);
        run_random(90, 100, 0);

        // R7: long stall drops words and sets overflow
        word_count = 16'd3; acc_cnt = 0;
        tick(1, 0, 0, 0);
        for (int i = 0; i < 120; i++) tick(0, 1, int'($urandom % 4096) - 2048, 0);
        chk(overflow == 1, "R7 overflow after stall", overflow, 1);
        run_random(100, 100, 0);
        chk(acc_cnt == 3, "R7 dropped words not counted", acc_cnt, 3);

        // R3 R4: full-scale saturation, positive then negative
        if_fcw = 0; doppler_fcw = 0; word_count = 16'd1;
        tick(1, 0, 0, 1);
        for (int i = 0; i < 32; i++) tick(0, 1, 2047, 0);
        chk(out_data == 32'h7fff_0000, "R3 positive saturation", out_data, 32'h7fff_0000);
        tick(0, 0, 0, 1);
        tick(1, 0, 0, 1);
        for (int i = 0; i < 32; i++) tick(0, 1, -2048, 0);
        chk(out_data == 32'h8000_0000, "R4 negative saturation packing", out_data, 32'h8000_0000);
        tick(0, 0, 0, 1);
        tick(0, 0, 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule